// File: doc/BRIEF.md
# Rolling-Shutter Row Readout Sequencer

This block walks a binary-hit pixel matrix one row at a time in a fixed-length time slot. Each row has a single control line. A one-cycle pulse on line k reads row k and clears the hit latches of row k-1. Reading row k+1 therefore also wipes row k, and no separate clear phase is needed. The row read in a slot is held on a column bus, with all columns at once, together with the row index and a valid strobe. The end-of-column logic downstream consumes them.

After the last row, one more pulse on a spare line clears the last row and flags the end of the frame. If start is still high, the scan wraps to row 0; otherwise the block goes idle. For testing, the block contains a behavioural model of the pixel hit latches. A latch is set by an injected hit and only records that a hit occurred. Clearing it is the only way to drop the hit.

Top module: `rs_readout_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, every control line, `row_valid_o` and `frame_done_o` are low, `row_idx_o` is 0 and `col_data_o` is 0. Reset also empties all hit latches.
- R2: In idle, a high `start_i` at a clock edge begins a frame. In the next cycle, control line 0 (bit 0 of `row_ctrl_o`) is high and is the only line high.
- R3: Row r's slot is `SLOT_CYCLES` (default 16) cycles long, and slot r+1 follows directly. Line r is high only in the first cycle of slot r. At most one line is high in any cycle.
- R4: In cycles 1 to `SLOT_CYCLES-1` of slot r, the following hold:
  - `row_valid_o` is high and `row_idx_o` equals r and does not change.
  - `col_data_o` bit c shows whether column c of row r held a hit at the edge that ends the pulse on line r.
- R5: The pulse on line r+1 clears the latches of row r. A reported hit therefore reads 0 in the next frame unless a new hit arrives.
- R6: After the last row's slot comes one extra cycle:
  - Line `NUM_ROWS` (the top bit of `row_ctrl_o`) clears the last row, and `frame_done_o` is high.
  - Line 0 follows in the next cycle if `start_i` is high. Otherwise the block returns to idle with row index 0.
- R7: A hit on row r sampled at the same edge as the clear of row r survives the clear and is reported in the next frame.
- R8: A hit on row r sampled at the edge that ends line r's pulse, or later in that slot, is not reported in the current frame. It is removed by the pulse on line r+1, so the next frame reads 0.
- R9: `start_i` has no effect while a frame is in progress: the row sequence neither restarts nor skips.
- R10: In idle, no control line is driven and injected hits stay in their latches. Several hits in one row are all reported together in that row's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a frame from idle; when high at frame end, continues the scan |
| hit_valid_i | input | 1 | Injects a hit into the latch model this cycle |
| hit_row_i | input | ROW_W | Row of the injected hit |
| hit_col_i | input | COL_W | Column of the injected hit |
| row_ctrl_o | output | NUM_ROWS+1 | Per-row control lines; bit k reads row k and clears row k-1; top bit clears the last row |
| row_idx_o | output | ROW_W | Row being presented |
| row_valid_o | output | 1 | Column data valid for `row_idx_o` |
| col_data_o | output | NUM_COLS | Hit bits of the presented row, bit c for column c |
| frame_done_o | output | 1 | One-cycle flag during the extra clear after the last row |

## Verification
Hits are preloaded in idle into the first, a middle and the last row. Some are single-column and one row has every column set. This shows that column bits are not mixed up and that the row mux selects the right row.

Mid-frame hits are then placed at three instants:
- On the edge where their row is cleared.
- On the edge where their row is read.
- Partway through their row's slot.

Together they separate set-over-clear priority from read-then-clear ordering. A second frame then shows which hits were wiped by the shared line, and that the extra pulse emptied the last row. Toggling start in mid-frame, and ending a frame with start low, separate wrap from stop.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SCAN  = 2'd1,
    SEQ_FLUSH = 2'd2
  } seq_state_e;

  // Cycle offset, from the first pulse of a frame, of the pulse for a row.
  function automatic int unsigned pulse_offset(input int unsigned row,
                                               input int unsigned slot);
    return row * slot;
  endfunction

  // Length of a full frame including the trailing clear cycle.
  function automatic int unsigned frame_cycles(input int unsigned rows,
                                               input int unsigned slot);
    return rows * slot + 1;
  endfunction

endpackage

// File: rtl/rs_row_timer.sv
module rs_row_timer
  import rs_seq_pkg::*;
#(
  parameter int NUM_ROWS    = 512,
  parameter int SLOT_CYCLES = 16,
  parameter int ROW_W       = $clog2(NUM_ROWS),
  parameter int CYC_W       = $clog2(SLOT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output seq_state_e       state_o,
  output logic [ROW_W-1:0] row_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             slot_start_o,
  output logic             flush_o
);

  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(SLOT_CYCLES - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  seq_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [CYC_W-1:0] cyc_q;
  logic             slot_end;

  assign slot_end = (state_q == SEQ_SCAN) && (cyc_q == LAST_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      row_q   <= '0;
      cyc_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_SCAN;
            row_q   <= '0;
            cyc_q   <= '0;
          end
        end
        SEQ_SCAN: begin
          if (slot_end) begin
            cyc_q <= '0;
            if (row_q == LAST_ROW) begin
              state_q <= SEQ_FLUSH;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        SEQ_FLUSH: begin
          row_q   <= '0;
          cyc_q   <= '0;
          state_q <= start_i ? SEQ_SCAN : SEQ_IDLE;
        end
        default: begin
          state_q <= SEQ_IDLE;
          row_q   <= '0;
          cyc_q   <= '0;
        end
      endcase
    end
  end

  assign state_o      = state_q;
  assign row_o        = row_q;
  assign cyc_o        = cyc_q;
  assign slot_start_o = (state_q == SEQ_SCAN) && (cyc_q == '0);
  assign flush_o      = (state_q == SEQ_FLUSH);

endmodule

// File: rtl/rs_ctrl_decode.sv
module rs_ctrl_decode #(
  parameter int NUM_ROWS = 512,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic               slot_start_i,
  input  logic               flush_i,
  input  logic [ROW_W-1:0]   row_i,
  output logic [NUM_ROWS:0]  ctrl_o
);

  for (genvar k = 0; k < NUM_ROWS; k++) begin : g_line
    assign ctrl_o[k] = slot_start_i && (row_i == ROW_W'(k));
  end

  // Spare line: clears the last row only.
  assign ctrl_o[NUM_ROWS] = flush_i;

endmodule

// File: rtl/rs_pixel_rows.sv
module rs_pixel_rows #(
  parameter int NUM_ROWS = 512,
  parameter int NUM_COLS = 4,
  parameter int ROW_W    = $clog2(NUM_ROWS),
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hit_valid_i,
  input  logic [ROW_W-1:0]    hit_row_i,
  input  logic [COL_W-1:0]    hit_col_i,
  input  logic [NUM_ROWS-1:0] clear_i,
  input  logic                read_en_i,
  input  logic [ROW_W-1:0]    read_row_i,
  output logic [NUM_COLS-1:0] col_q_o
);

  logic [NUM_COLS-1:0] hit_q [NUM_ROWS];
  logic [NUM_COLS-1:0] col_q;
  logic [NUM_COLS-1:0] col_onehot;

  assign col_onehot = NUM_COLS'(1) << hit_col_i;

  // Each latch: set by a hit, cleared by its row's clear; set wins.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [NUM_COLS-1:0] set_v;
    assign set_v = (hit_valid_i && (hit_row_i == ROW_W'(r))) ? col_onehot : '0;
    always_ff @(posedge clk) begin
      if (rst) begin
        hit_q[r] <= '0;
      end else begin
        hit_q[r] <= set_v | (hit_q[r] & ~{NUM_COLS{clear_i[r]}});
      end
    end
  end

  // Snapshot of the selected row onto the shared column lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
    end else if (read_en_i) begin
      col_q <= hit_q[read_row_i];
    end
  end

  assign col_q_o = col_q;

endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
  import rs_seq_pkg::*;
#(
  parameter int NUM_ROWS    = 512,
  parameter int NUM_COLS    = 4,
  parameter int SLOT_CYCLES = 16,
  parameter int ROW_W       = $clog2(NUM_ROWS),
  parameter int COL_W       = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                hit_valid_i,
  input  logic [ROW_W-1:0]    hit_row_i,
  input  logic [COL_W-1:0]    hit_col_i,
  output logic [NUM_ROWS:0]   row_ctrl_o,
  output logic [ROW_W-1:0]    row_idx_o,
  output logic                row_valid_o,
  output logic [NUM_COLS-1:0] col_data_o,
  output logic                frame_done_o
);

  localparam int CYC_W = $clog2(SLOT_CYCLES);

  seq_state_e       state_w;
  logic [ROW_W-1:0] row_w;
  logic [CYC_W-1:0] cyc_w;
  logic             slot_start_w;
  logic             flush_w;
  logic [NUM_ROWS:0] ctrl_w;

  rs_row_timer #(
    .NUM_ROWS    (NUM_ROWS),
    .SLOT_CYCLES (SLOT_CYCLES),
    .ROW_W       (ROW_W),
    .CYC_W       (CYC_W)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .state_o      (state_w),
    .row_o        (row_w),
    .cyc_o        (cyc_w),
    .slot_start_o (slot_start_w),
    .flush_o      (flush_w)
  );

  rs_ctrl_decode #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W)
  ) u_decode (
    .slot_start_i (slot_start_w),
    .flush_i      (flush_w),
    .row_i        (row_w),
    .ctrl_o       (ctrl_w)
  );

  rs_pixel_rows #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W)
  ) u_pixels (
    .clk         (clk),
    .rst         (rst),
    .hit_valid_i (hit_valid_i),
    .hit_row_i   (hit_row_i),
    .hit_col_i   (hit_col_i),
    .clear_i     (ctrl_w[NUM_ROWS:1]),
    .read_en_i   (slot_start_w),
    .read_row_i  (row_w),
    .col_q_o     (col_data_o)
  );

  assign row_ctrl_o   = ctrl_w;
  assign row_idx_o    = row_w;
  assign row_valid_o  = (state_w == SEQ_SCAN) && (cyc_w != '0);
  assign frame_done_o = flush_w;

endmodule

// File: rtl/rs_readout_seq_chk.sv
module rs_readout_seq_chk #(
  parameter int NUM_ROWS    = 512,
  parameter int NUM_COLS    = 4,
  parameter int SLOT_CYCLES = 16,
  parameter int ROW_W       = $clog2(NUM_ROWS)
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_ROWS:0]   row_ctrl,
  input logic [ROW_W-1:0]    row_idx,
  input logic                row_valid,
  input logic [NUM_COLS-1:0] col_data,
  input logic                frame_done,
  input logic                slot_start
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

  logic [15:0] run_len;
  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (row_valid) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (row_ctrl == '0) && !row_valid && !frame_done && (row_idx == '0)
            && (col_data == '0));

  // R3
  ctrl_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_ctrl));

  // R3
  ctrl_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (row_ctrl != '0) |=> ((row_ctrl & $past(row_ctrl)) == '0));

  // R3
  slot_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(row_valid) |-> (run_len == 16'(SLOT_CYCLES - 1)));

  // R4
  valid_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    slot_start |=> row_valid && (row_idx == $past(row_idx)));

  // R4
  idx_stable_chk: assert property (@(posedge clk) disable iff (rst)
    row_valid |=> !row_valid || ($stable(row_idx) && $stable(col_data)));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> $past(row_valid) && (row_idx == LAST_ROW));

  // R6
  wrap_or_idle_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> row_ctrl[0] || ((row_ctrl == '0) && !row_valid && (row_idx == '0)));

endmodule

bind rs_readout_seq rs_readout_seq_chk #(
  .NUM_ROWS    (NUM_ROWS),
  .NUM_COLS    (NUM_COLS),
  .SLOT_CYCLES (SLOT_CYCLES),
  .ROW_W       (ROW_W)
) u_seq_chk (
  .clk        (clk),
  .rst        (rst),
  .row_ctrl   (row_ctrl_o),
  .row_idx    (row_idx_o),
  .row_valid  (row_valid_o),
  .col_data   (col_data_o),
  .frame_done (frame_done_o),
  .slot_start (slot_start_w)
);

// File: tb/test_rs_readout_seq.sv
`timescale 1ns/1ps
module test_rs_readout_seq;

  localparam int ROWS  = 512;
  localparam int COLS  = 4;
  localparam int SLOT  = 16;
  localparam int RW    = 9;
  localparam int CW    = 2;
  localparam int FRAME = ROWS * SLOT + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic            hit_valid_i = 1'b0;
  logic [RW-1:0]   hit_row_i = '0;
  logic [CW-1:0]   hit_col_i = '0;
  logic [ROWS:0]   row_ctrl_o;
  logic [RW-1:0]   row_idx_o;
  logic            row_valid_o;
  logic [COLS-1:0] col_data_o;
  logic            frame_done_o;

  int tests = 0;
  int fails = 0;
  int pos   = 0;

  always #4 clk = ~clk;

  rs_readout_seq #(
    .NUM_ROWS    (ROWS),
    .NUM_COLS    (COLS),
    .SLOT_CYCLES (SLOT)
  ) i_rs_readout_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .hit_valid_i  (hit_valid_i),
    .hit_row_i    (hit_row_i),
    .hit_col_i    (hit_col_i),
    .row_ctrl_o   (row_ctrl_o),
    .row_idx_o    (row_idx_o),
    .row_valid_o  (row_valid_o),
    .col_data_o   (col_data_o),
    .frame_done_o (frame_done_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic adv(input int target);
    repeat (target - pos) @(negedge clk);
    pos = target;
  endtask

  task automatic hit(input int r, input int c);
    hit_valid_i = 1'b1;
    hit_row_i   = RW'(r);
    hit_col_i   = CW'(c);
    @(negedge clk);
    hit_valid_i = 1'b0;
    pos++;
  endtask

  task automatic row_data(input string req, input int r, input int exp);
    adv(r * SLOT + 1);
    chk(req, $sformatf("row %0d valid", r), row_valid_o, 1);
    chk(req, $sformatf("row %0d index", r), row_idx_o, r);
    chk(req, $sformatf("row %0d data", r), col_data_o, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ctrl lines", $countones(row_ctrl_o), 0);
    chk("R1", "row_valid", row_valid_o, 0);
    chk("R1", "row_idx", row_idx_o, 0);
    chk("R1", "frame_done", frame_done_o, 0);
    chk("R1", "col_data", col_data_o, 0);
  endtask

  task automatic t_idle_hits();
    hit(0, 0); hit(0, 2); hit(5, 3);
    for (int c = 0; c < COLS; c++) hit(511, c);
    repeat (40) @(negedge clk);
    chk("R10", "idle ctrl lines", $countones(row_ctrl_o), 0);
    chk("R10", "idle row_valid", row_valid_o, 0);
  endtask

  task automatic t_frame1();
    start_i = 1'b1;
    @(negedge clk);
    pos = 0;
    chk("R2", "line 0 after start", row_ctrl_o[0], 1);
    chk("R2", "single line", $countones(row_ctrl_o), 1);
    chk("R2", "valid low in pulse", row_valid_o, 0);
    row_data("R10", 0, 4'b0101);
    adv(SLOT - 1);
    chk("R4", "valid at slot end", row_valid_o, 1);
    chk("R4", "index at slot end", row_idx_o, 0);
    adv(SLOT);
    chk("R3", "line 1 pulse", row_ctrl_o[1], 1);
    chk("R3", "valid low at pulse", row_valid_o, 0);
    chk("R3", "index steps", row_idx_o, 1);
    row_data("R4", 1, 0);
    adv(3 * SLOT);
    chk("R7", "line 3 visible", row_ctrl_o[3], 1);
    hit(2, 1);
    row_data("R4", 5, 4'b1000);
    adv(100);
    hit(300, 1);
    adv(7 * SLOT);
    chk("R8", "line 7 visible", row_ctrl_o[7], 1);
    hit(7, 0);
    chk("R8", "row 7 misses late hit", col_data_o, 0);
    adv(9 * SLOT + 4);
    hit(9, 2);
    row_data("R4", 300, 4'b0010);
    row_data("R10", 511, 4'b1111);
    adv(ROWS * SLOT);
    chk("R6", "extra line", row_ctrl_o[ROWS], 1);
    chk("R6", "extra single line", $countones(row_ctrl_o), 1);
    chk("R6", "frame_done", frame_done_o, 1);
    chk("R6", "valid low in flush", row_valid_o, 0);
    adv(FRAME);
    chk("R6", "wrap line 0", row_ctrl_o[0], 1);
    chk("R6", "wrap index", row_idx_o, 0);
    chk("R6", "done drops", frame_done_o, 0);
    pos = 0;
  endtask

  task automatic t_frame2();
    row_data("R5", 0, 0);
    row_data("R7", 2, 4'b0010);
    row_data("R8", 7, 0);
    row_data("R8", 9, 0);
    adv(10 * SLOT + 2);
    start_i = 1'b0;
    adv(10 * SLOT + 5);
    start_i = 1'b1;
    @(negedge clk);
    pos++;
    start_i = 1'b0;
    adv(10 * SLOT + 8);
    chk("R9", "index kept", row_idx_o, 10);
    chk("R9", "valid kept", row_valid_o, 1);
    row_data("R9", 11, 0);
    row_data("R5", 300, 0);
    row_data("R6", 511, 0);
    adv(ROWS * SLOT);
    chk("R6", "frame_done frame 2", frame_done_o, 1);
    adv(FRAME);
    chk("R6", "idle ctrl", $countones(row_ctrl_o), 0);
    chk("R6", "idle valid", row_valid_o, 0);
    chk("R6", "idle index", row_idx_o, 0);
  endtask

  task automatic t_restart();
    hit(4, 1);
    repeat (5) @(negedge clk);
    chk("R10", "still idle", $countones(row_ctrl_o), 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    pos = 0;
    chk("R2", "restart line 0", row_ctrl_o[0], 1);
    row_data("R2", 4, 4'b0010);
  endtask

  initial begin
    t_reset();
    t_idle_hits();
    t_frame1();
    t_frame2();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule